// File: doc/BRIEF.md
# Nibble-Wide CRC5 Generator

This block keeps a running 5-bit cyclic redundancy checksum over the generator polynomial x^5 + x^2 + 1, the five-bit checksum used on serial bus token packets. A bit-serial shift register would need four clocks to take in four data bits. This block takes in a whole 4-bit nibble in a single clock. Its next state comes from a flat XOR network of the current checksum and the incoming nibble.

The surrounding logic first pulses `init` to seed the register with all ones. It then presents nibbles with `data_valid` high. The running checksum on `crc_out` can be read at any time. Framing, insertion of the checksum into a stream and checking of received checksums belong to other blocks.

A small decoder turns the control inputs into one of three named register actions:
- `ACT_LOAD` seeds the register. It is chosen when `init` is high.
- `ACT_STEP` advances the register by one nibble. It is chosen when `data_valid` is high and `init` is low.
- `ACT_HOLD` keeps the register unchanged. It is chosen when both inputs are low.

The register moves from any action to any other on each clock, as the inputs choose.

Top module: `crc5_nibble_gen`

## Requirements
- R1: One accepted nibble gives the same checksum as four serial steps, with `data_in[3]` shifted first and `data_in[0]` last. In each serial step the feedback is the old bit 4 XOR the data bit, the register shifts toward bit 4, and the feedback enters bit 0 and is also XORed into bit 2.
- R2: A cycle with `init` high loads `crc_out` with 5'h1F at the next clock edge.
- R3: When `init` and `data_valid` are both high in the same cycle, `init` wins and the result is 5'h1F.
- R4: In a cycle with `init` and `data_valid` both low, `crc_out` keeps its value whatever `data_in` carries.
- R5: The checksum changes at the clock edge that samples `data_valid` high, and at no earlier point.
- R6: Starting from 5'h1F, the nibble sequence 0x0, 0xF, 0x5, 0xA, 0x3, 0x8 gives the checksums 0x06, 0x19, 0x18, 0x1E, 0x19 and 0x04, one after each nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything updates on the rising edge |
| init | input | 1 | Synchronous seed of the checksum to all ones |
| data_valid | input | 1 | Marks `data_in` as a nibble to absorb |
| data_in | input | 4 | Data nibble; bit 3 counts as the earliest serial bit |
| crc_out | output | 5 | Current checksum register |

## Verification
The assertions check four behaviours on every clock after the first seed:
- the seed value after `init`, including when `init` and `data_valid` are both high;
- that the register holds in idle cycles;
- that every accepted nibble moves the register to the value that four serial steps would give.

Only the bench's scenarios can show the following: the one-cycle latency seen from outside, the fixed checksum sequence from the seed, and agreement with an independent bit-serial model over long random streams with gaps.

// File: rtl/crc5_pkg.sv
package crc5_pkg;

    localparam int unsigned CRC_W    = 5;
    localparam int unsigned NIBBLE_W = 4;
    localparam logic [CRC_W-1:0] POLY_TAPS = 5'h05;
    localparam logic [CRC_W-1:0] SEED      = 5'h1F;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } crc_act_e;

endpackage

// File: rtl/crc5_xor_net.sv
module crc5_xor_net #(
    parameter int unsigned CW = 5,
    parameter int unsigned DW = 4,
    parameter logic [CW-1:0] TAPS = 5'h05
) (
    input  logic [CW-1:0] cur,
    input  logic [DW-1:0] din,
    output logic [CW-1:0] nxt
);
    localparam bit FIXED_FORM = (CW == 5) && (DW == 4) && (TAPS == 5'h05);

    generate
        if (FIXED_FORM) begin : g_flat
            // Hand-flattened equations for the five-bit, four-bit-wide case.
            always_comb begin
                nxt[0] = cur[1] ^ cur[4] ^ din[0] ^ din[3];
                nxt[1] = cur[2] ^ din[1];
                nxt[2] = cur[1] ^ cur[3] ^ cur[4] ^ din[0] ^ din[2] ^ din[3];
                nxt[3] = cur[2] ^ cur[4] ^ din[1] ^ din[3];
                nxt[4] = cur[0] ^ cur[3] ^ din[2];
            end
        end else begin : g_unrolled
            // Other widths: unroll the serial recurrence, MSB of data first.
            always_comb begin
                logic [CW-1:0] s;
                logic          fb;
                s = cur;
                for (int i = DW - 1; i >= 0; i--) begin
                    fb = s[CW-1] ^ din[i];
                    s  = {s[CW-2:0], 1'b0} ^ ({CW{fb}} & TAPS);
                end
                nxt = s;
            end
        end
    endgenerate
endmodule

// File: rtl/crc5_act_dec.sv
module crc5_act_dec
    import crc5_pkg::*;
(
    input  logic     seed_req,
    input  logic     take_req,
    output crc_act_e act
);
    always_comb begin
        if (seed_req)      act = ACT_LOAD;
        else if (take_req) act = ACT_STEP;
        else               act = ACT_HOLD;
    end
endmodule

// File: rtl/crc5_state_reg.sv
module crc5_state_reg
    import crc5_pkg::*;
#(
    parameter int unsigned CW = 5,
    parameter logic [CW-1:0] SEED_VAL = 5'h1F
) (
    input  logic          clk,
    input  crc_act_e      act,
    input  logic [CW-1:0] step_val,
    output logic [CW-1:0] q
);
    logic [CW-1:0] q_r;

    always_ff @(posedge clk) begin
        unique case (act)
            ACT_LOAD: q_r <= SEED_VAL;
            ACT_STEP: q_r <= step_val;
            ACT_HOLD: q_r <= q_r;
            default:  q_r <= q_r;
        endcase
    end

    always_comb q = q_r;

    // Checks are enabled only after the first seed.
    logic armed = 1'b0;
    always_ff @(posedge clk) if (act == ACT_LOAD) armed <= 1'b1;

    a_r2_seed_loads: assert property (@(posedge clk) disable iff (!armed)
        act == ACT_LOAD |=> q == SEED_VAL);
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!armed)
        act == ACT_HOLD |=> $stable(q));
endmodule

// File: rtl/crc5_nibble_gen.sv
module crc5_nibble_gen
    import crc5_pkg::*;
#(
    parameter int unsigned CW = CRC_W,
    parameter int unsigned DW = NIBBLE_W,
    parameter logic [CW-1:0] TAPS = POLY_TAPS,
    parameter logic [CW-1:0] SEED_VAL = SEED
) (
    input  logic          clk,
    input  logic          init,
    input  logic          data_valid,
    input  logic [DW-1:0] data_in,
    output logic [CW-1:0] crc_out
);
    crc_act_e      act;
    logic [CW-1:0] next_val;
    logic [CW-1:0] cur_val;

    crc5_act_dec u_dec (
        .seed_req (init),
        .take_req (data_valid),
        .act      (act)
    );

    crc5_xor_net #(.CW(CW), .DW(DW), .TAPS(TAPS)) u_net (
        .cur (cur_val),
        .din (data_in),
        .nxt (next_val)
    );

    crc5_state_reg #(.CW(CW), .SEED_VAL(SEED_VAL)) u_reg (
        .clk      (clk),
        .act      (act),
        .step_val (next_val),
        .q        (cur_val)
    );

    assign crc_out = cur_val;

    // Bit-serial reference, kept apart from the flat network.
    logic [CW-1:0] ser_ref;
    always_comb begin
        logic [CW-1:0] s;
        logic          fb;
        s = crc_out;
        for (int i = DW - 1; i >= 0; i--) begin
            fb = s[CW-1] ^ data_in[i];
            s  = {s[CW-2:0], 1'b0} ^ ({CW{fb}} & TAPS);
        end
        ser_ref = s;
    end

    logic armed = 1'b0;
    always_ff @(posedge clk) if (init) armed <= 1'b1;

    a_r1_matches_serial: assert property (@(posedge clk) disable iff (!armed)
        (data_valid && !init) |=> crc_out == $past(ser_ref));
    a_r3_seed_wins: assert property (@(posedge clk) disable iff (!armed)
        (init && data_valid) |=> crc_out == SEED_VAL);
endmodule

// File: tb/tb_crc5_nibble_gen.sv
module tb_crc5_nibble_gen;
    logic       clk = 1'b0;
    logic       init = 1'b0;
    logic       data_valid = 1'b0;
    logic [3:0] data_in = 4'h0;
    logic [4:0] crc_out;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    crc5_nibble_gen dut (
        .clk(clk), .init(init), .data_valid(data_valid),
        .data_in(data_in), .crc_out(crc_out)
    );

    // {nibble, expected checksum}, chained from the seed (R6)
    localparam logic [8:0] VEC [6] = '{
        {4'h0, 5'h06}, {4'hF, 5'h19}, {4'h5, 5'h18},
        {4'hA, 5'h1E}, {4'h3, 5'h19}, {4'h8, 5'h04}
    };

    function automatic logic [4:0] ser_model(input logic [4:0] c, input logic [3:0] d);
        logic [4:0] s = c;
        for (int i = 3; i >= 0; i--) begin
            logic fb = s[4] ^ d[i];
            s = {s[3:0], 1'b0};
            s[0] = s[0] ^ fb;
            s[2] = s[2] ^ fb;
        end
        return s;
    endfunction

    task automatic check(input string req, input logic [4:0] exp_v);
        tests++;
        if (crc_out !== exp_v) begin
            fails++;
            $display("FAIL %s: crc_out=%h expected=%h", req, crc_out, exp_v);
        end
    endtask

    // drive at negedge, result visible by next negedge
    task automatic cycle(input logic i, input logic v, input logic [3:0] d);
        init = i; data_valid = v; data_in = d;
        @(negedge clk);
        init = 1'b0; data_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: crc_out=%h expected=finish", crc_out);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [4:0] model;
        @(negedge clk);
        cycle(1'b1, 1'b0, 4'h0);
        check("R2 seed after init", 5'h1F);

        foreach (VEC[k]) begin
            cycle(1'b0, 1'b1, VEC[k][8:5]);
            check("R6 table vector", VEC[k][4:0]);
        end

        // R4: idle cycles with changing data
        for (int k = 0; k < 4; k++) begin
            cycle(1'b0, 1'b0, 4'(k * 5 + 3));
            check("R4 hold when idle", 5'h04);
        end

        // R5: no change before the sampling edge
        init = 1'b0; data_valid = 1'b1; data_in = 4'h9;
        #1;
        check("R5 no early change", 5'h04);
        @(negedge clk);
        data_valid = 1'b0;
        check("R5 update after one edge", ser_model(5'h04, 4'h9));

        // R3: init with valid
        cycle(1'b1, 1'b1, 4'hF);
        check("R3 init beats valid", 5'h1F);

        // R1: random streams with gaps against serial model
        model = 5'h1F;
        for (int k = 0; k < 400; k++) begin
            logic v = ($urandom % 4) != 0;
            logic [3:0] d = 4'($urandom);
            cycle(1'b0, v, d);
            if (v) model = ser_model(model, d);
            check("R1 serial equivalence", model);
            if (k == 200) begin
                cycle(1'b1, 1'b0, 4'h0);
                check("R2 init mid-stream", 5'h1F);
                model = 5'h1F;
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule